// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory with a shared data path. It can take a new read, write or deselect command on every enabled clock edge. Switching between reads and writes costs no idle cycles, because write data is taken two enabled edges after its command. That is the same slot in which read data would occupy the bus. Each word holds 32 data bits in four byte lanes, and each lane has one parity bit. A write can update any subset of the lanes. The word count is a parameter.

A command is loaded when the load strobe is low and all three selects are active. Holding the load strobe high advances a two-bit burst counter instead. The burst keeps the read or write type that was loaded, and the counter walks the low two address bits in linear or interleaved order. An active-low run enable stretches the previous cycle: while it is high, no state anywhere moves. A write that is still in flight keeps its address and lane mask until the next enabled edge.

The access state is a three-state machine on the current command slot:
- ACC_IDLE means deselected.
- ACC_READ means a read is in the slot.
- ACC_WRITE means a write is in the slot.

The state machine has five transitions:
- LOAD_RD goes to ACC_READ on a selected load with write enable high.
- LOAD_WR goes to ACC_WRITE on a selected load with write enable low.
- LOAD_OFF goes to ACC_IDLE on a load with any select inactive.
- ADVANCE keeps the state and steps the counter.
- HOLD keeps everything when the run enable is high.

Top module: `zt_sram`

## Requirements
- R1: A command is loaded only on an edge where run_n=0 and load_n=0 and the selects read sel_a_n=0, sel_b=1, sel_c_n=0. Any other select pattern on a load deselects, and rd_oe is 0 after the following enabled edge.
- R2: A read loaded at enabled edge N presents the addressed word on rd_data/rd_par with rd_oe=1 after enabled edge N+1.
- R3: A write loaded at enabled edge N takes wd_in/wp_in at enabled edge N+2. Reads and writes may alternate on consecutive edges with no idle cycle.
- R4: Lane k (lane_wr_n[k]=0) covers data bits 8k+7:8k and parity bit k. Lanes whose select is 1 keep their old contents. The mask is taken on the edge where the write beat is issued.
- R5: With run_n=1 an edge has no effect: rd_oe, rd_data, rd_par, the burst position and any pending write are held, and the write data on the bus at that edge is ignored.
- R6: A read whose slot meets a pending write to the same address returns the newly written lanes, merged with the unwritten old lanes.
- R7: When load_n=1 on an enabled edge, the burst advances. The selects and we_n are ignored, and the read/write type is kept. The low address bits run base+k mod 4 when burst_ilv=0 and base XOR k when burst_ilv=1, for beat k=0..3.
- R8: Synchronous active-high rst clears every valid bit and leaves the block deselected. rd_oe is 0, and it stays 0 across advance cycles that follow.
- R9: After an enabled edge that moves a write or a deselect out of the command slot, rd_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_n | input | 1 | Clock enable, active low; high holds all state |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| we_n | input | 1 | Write enable, active low, taken on load |
| load_n | input | 1 | Low loads a new command, high advances the burst |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| addr | input | AW | Word address |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| wd_in | input | 8*LANES | Write data bus |
| wp_in | input | LANES | Write parity bus |
| rd_data | output | 8*LANES | Read data register |
| rd_par | output | LANES | Read parity register |
| rd_oe | output | 1 | Read data valid, i.e. drive enable for the bus |

## Verification
A memory commit and a read can fall on the same enabled edge: a write's data phase coincides with the output phase of a read loaded right after it. The bench provokes this by following each write with a read of the same address. It sweeps all sixteen lane masks that way, and also mixes the two in a long random stream with stalls. The bench's arithmetic memory model applies the commit before serving the read, so the merged word it expects is judged lane by lane against rd_data and rd_par.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    localparam int LANE_BITS = 8;
    localparam int BURST_W   = 2;
endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq #(
    parameter int AW = 6
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    beat,
    input  logic          ilv,
    output logic [AW-1:0] addr_out
);
    logic [1:0] low;

    always_comb begin
        if (ilv) low = base[1:0] ^ beat;
        else     low = base[1:0] + beat;
        addr_out = {base[AW-1:2], low};
    end
endmodule

// File: rtl/zt_lane_merge.sv
module zt_lane_merge #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] old_d,
    input  logic [LANES-1:0]   old_p,
    input  logic [8*LANES-1:0] new_d,
    input  logic [LANES-1:0]   new_p,
    input  logic [LANES-1:0]   take,
    output logic [8*LANES-1:0] out_d,
    output logic [LANES-1:0]   out_p
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign out_d[8*k +: 8] = take[k] ? new_d[8*k +: 8] : old_d[8*k +: 8];
        assign out_p[k]        = take[k] ? new_p[k]        : old_p[k];
    end
endmodule

// File: rtl/zt_word_store.sv
module zt_word_store #(
    parameter int DEPTH = 64,
    parameter int LANES = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_go,
    input  logic [AW-1:0]      wr_addr,
    input  logic [LANES-1:0]   wr_lanes,
    input  logic [8*LANES-1:0] wr_d,
    input  logic [LANES-1:0]   wr_p,
    input  logic [AW-1:0]      rd_addr,
    output logic [8*LANES-1:0] rd_d,
    output logic [LANES-1:0]   rd_p
);
    for (genvar k = 0; k < LANES; k++) begin : g_bank
        logic [8:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_go && wr_lanes[k])
                cells[wr_addr] <= {wr_p[k], wr_d[8*k +: 8]};
        end

        assign rd_d[8*k +: 8] = cells[rd_addr][7:0];
        assign rd_p[k]        = cells[rd_addr][8];
    end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LANES = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int DW = LANE_BITS * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             we_n,
    input  logic             load_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic [AW-1:0]    addr,
    input  logic             burst_ilv,
    input  logic [DW-1:0]    wd_in,
    input  logic [LANES-1:0] wp_in,
    output logic [DW-1:0]    rd_data,
    output logic [LANES-1:0] rd_par,
    output logic             rd_oe
);
    // command slot (stage 1) state
    acc_e               acc_q, acc_d;
    logic [AW-1:0]      base_q, base_d;
    logic [BURST_W-1:0] beat_q, beat_d;
    logic [LANES-1:0]   mask_q;
    logic [AW-1:0]      s1_addr;

    // data-phase (stage 2) write slot
    logic               s2_vld;
    logic [AW-1:0]      s2_addr;
    logic [LANES-1:0]   s2_mask;

    logic               sel_ok;
    logic               step;
    logic [DW-1:0]      mem_d, fwd_d;
    logic [LANES-1:0]   mem_p, fwd_p;
    logic [LANES-1:0]   fwd_take;

    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
    assign step   = !run_n;

    zt_burst_seq #(.AW(AW)) u_seq (
        .base     (base_q),
        .beat     (beat_q),
        .ilv      (burst_ilv),
        .addr_out (s1_addr)
    );

    zt_word_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
        .clk      (clk),
        .wr_go    (step && s2_vld && !rst),
        .wr_addr  (s2_addr),
        .wr_lanes (s2_mask),
        .wr_d     (wd_in),
        .wr_p     (wp_in),
        .rd_addr  (s1_addr),
        .rd_d     (mem_d),
        .rd_p     (mem_p)
    );

    // bytes committed on this very edge are forwarded to a read in the slot
    assign fwd_take = (s2_vld && (s2_addr == s1_addr)) ? s2_mask : '0;

    zt_lane_merge #(.LANES(LANES)) u_fwd (
        .old_d (mem_d),
        .old_p (mem_p),
        .new_d (wd_in),
        .new_p (wp_in),
        .take  (fwd_take),
        .out_d (fwd_d),
        .out_p (fwd_p)
    );

    // next-state: LOAD_RD / LOAD_WR / LOAD_OFF / ADVANCE
    always_comb begin
        acc_d  = acc_q;
        base_d = base_q;
        beat_d = beat_q;
        if (!load_n) begin
            beat_d = '0;
            base_d = addr;
            if (!sel_ok)   acc_d = ACC_IDLE;
            else if (we_n) acc_d = ACC_READ;
            else           acc_d = ACC_WRITE;
        end else begin
            beat_d = beat_q + 1'b1;
        end
    end

    // state register; HOLD when run_n is high
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= ACC_IDLE;
            base_q <= '0;
            beat_q <= '0;
            mask_q <= '0;
        end else if (step) begin
            acc_q  <= acc_d;
            base_q <= base_d;
            beat_q <= beat_d;
            mask_q <= ~lane_wr_n;
        end
    end

    // outputs and data-phase slot, driven by the slot state
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_vld  <= 1'b0;
            s2_addr <= '0;
            s2_mask <= '0;
            rd_oe   <= 1'b0;
            rd_data <= '0;
            rd_par  <= '0;
        end else if (step) begin
            s2_addr <= s1_addr;
            s2_mask <= mask_q;
            unique case (acc_q)
                ACC_READ: begin
                    s2_vld  <= 1'b0;
                    rd_oe   <= 1'b1;
                    rd_data <= fwd_d;
                    rd_par  <= fwd_p;
                end
                ACC_WRITE: begin
                    s2_vld <= 1'b1;
                    rd_oe  <= 1'b0;
                end
                default: begin
                    s2_vld <= 1'b0;
                    rd_oe  <= 1'b0;
                end
            endcase
        end
    end

    a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
        (step && acc_q == ACC_READ) |=> rd_oe);

    a_r9_quiet_after_write_or_idle: assert property (@(posedge clk) disable iff (rst)
        (step && acc_q != ACC_READ) |=> !rd_oe);

    a_r3_write_reaches_data_phase: assert property (@(posedge clk) disable iff (rst)
        (step && acc_q == ACC_WRITE) |=> s2_vld);

    a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(rd_oe) && $stable(rd_data) && $stable(rd_par)
                   && $stable(acc_q) && $stable(s2_vld)));

    a_r1_deselect_on_bad_select: assert property (@(posedge clk) disable iff (rst)
        (step && !load_n && !sel_ok) |=> acc_q == ACC_IDLE);

    a_r7_advance_keeps_kind: assert property (@(posedge clk) disable iff (rst)
        (step && load_n) |=> $stable(acc_q));

    a_r6_full_forward: assert property (@(posedge clk) disable iff (rst)
        (step && acc_q == ACC_READ && s2_vld && s2_addr == s1_addr && &s2_mask)
        |=> (rd_data == $past(wd_in) && rd_par == $past(wp_in)));
endmodule

// File: tb/tb_zt_sram.sv
module tb_zt_sram;
    localparam int DEPTH = 16;
    localparam int LANES = 4;
    localparam int AW    = 4;
    localparam int DW    = 32;

    logic             clk = 1'b0;
    logic             rst;
    logic             run_n;
    logic             sel_a_n, sel_b, sel_c_n;
    logic             we_n, load_n;
    logic [LANES-1:0] lane_wr_n;
    logic [AW-1:0]    addr;
    logic             burst_ilv;
    logic [DW-1:0]    wd_in;
    logic [LANES-1:0] wp_in;
    logic [DW-1:0]    rd_data;
    logic [LANES-1:0] rd_par;
    logic             rd_oe;

    zt_sram #(.DEPTH(DEPTH), .LANES(LANES)) dut (
        .clk(clk), .rst(rst), .run_n(run_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .we_n(we_n), .load_n(load_n), .lane_wr_n(lane_wr_n),
        .addr(addr), .burst_ilv(burst_ilv), .wd_in(wd_in), .wp_in(wp_in),
        .rd_data(rd_data), .rd_par(rd_par), .rd_oe(rd_oe)
    );

    always #5 clk = ~clk;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R8";

    // bench model of the requirements
    logic [35:0]   m_mem [DEPTH];
    int            m_kind;      // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_base;
    int            m_beat;
    logic [3:0]    m_mask;
    logic          p2_v;
    logic [AW-1:0] p2_a;
    logic [3:0]    p2_m;
    logic          exp_oe;
    logic [35:0]   exp_w;
    logic [35:0]   slot1, slot2;  // data waiting for its bus slot (R3)
    logic [35:0]   last_w;

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, int k, logic ilv);
        logic [1:0] lo;
        lo = ilv ? (b[1:0] ^ 2'(k)) : (b[1:0] + 2'(k));
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [35:0] pat(int a, int salt);
        logic [31:0] d;
        d = 32'(a) * 32'h01030507 ^ 32'(salt) * 32'h9e3779b9;
        return {4'(a ^ salt ^ (salt >> 4)), d};
    endfunction

    task automatic check(string req, logic cond, logic [35:0] act, logic [35:0] expv);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // one clock: drive at negedge, model the edge, compare one time unit after it
    task automatic step(logic rn, logic [2:0] sel, logic w_n, logic ld_n,
                        logic [AW-1:0] a, logic [3:0] lw_n, logic [35:0] beat_w);
        logic [35:0] drv;
        logic [AW-1:0] s1;
        drv = rn ? ~slot2 : slot2;   // junk during a stall must be ignored (R5)
        run_n = rn; {sel_a_n, sel_b, sel_c_n} = sel; we_n = w_n; load_n = ld_n;
        addr = a; lane_wr_n = lw_n; wd_in = drv[31:0]; wp_in = drv[35:32];
        @(posedge clk);
        if (!rn) begin
            if (p2_v)
                for (int k = 0; k < 4; k++)
                    if (p2_m[k]) begin
                        m_mem[p2_a][8*k +: 8] = drv[8*k +: 8];
                        m_mem[p2_a][32+k]     = drv[32+k];
                    end
            s1 = beat_addr(m_base, m_beat, burst_ilv);
            exp_oe = (m_kind == 1);
            if (m_kind == 1) exp_w = m_mem[s1];
            p2_v = (m_kind == 2); p2_a = s1; p2_m = m_mask;
            if (!ld_n) begin
                if (sel == 3'b010) begin
                    m_kind = w_n ? 1 : 2; m_base = a; m_beat = 0;
                end else m_kind = 0;
            end else m_beat = (m_beat + 1) % 4;
            m_mask = ~lw_n;
            slot2 = slot1; slot1 = beat_w;
        end
        #1;
        check(cur_req, rd_oe == exp_oe, {35'd0, rd_oe}, {35'd0, exp_oe});
        if (exp_oe)
            check(cur_req, {rd_par, rd_data} == exp_w, {rd_par, rd_data}, exp_w);
        @(negedge clk);
    endtask

    task automatic do_rd(int a);
        step(1'b0, 3'b010, 1'b1, 1'b0, AW'(a), 4'hF, 36'd0);
    endtask
    task automatic do_wr(int a, logic [3:0] lw_n, logic [35:0] w);
        step(1'b0, 3'b010, 1'b0, 1'b0, AW'(a), lw_n, w);
    endtask
    task automatic do_off();
        step(1'b0, 3'b111, 1'b1, 1'b0, '0, 4'hF, 36'd0);
    endtask
    task automatic do_adv(logic [3:0] lw_n, logic [35:0] w);
        // selects and we_n driven to junk: must be ignored (R7)
        step(1'b0, 3'b101, 1'b0, 1'b1, AW'($urandom), lw_n, w);
    endtask
    task automatic do_hold();
        step(1'b1, 3'b010, 1'b0, 1'b0, AW'($urandom), 4'h0, 36'hFFFFFFFFF);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_kind = 0; m_base = '0; m_beat = 0; m_mask = '0;
        p2_v = 0; p2_a = '0; p2_m = '0; exp_oe = 0; exp_w = '0;
        slot1 = '0; slot2 = '0;
        rst = 1'b1; run_n = 1'b0; {sel_a_n, sel_b, sel_c_n} = 3'b111;
        we_n = 1'b1; load_n = 1'b0; lane_wr_n = 4'hF; addr = '0;
        burst_ilv = 1'b0; wd_in = '0; wp_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: reset leaves outputs off, and advancing stays deselected
        cur_req = "R8";
        check("R8", rd_oe == 1'b0, {35'd0, rd_oe}, 36'd0);
        do_adv(4'hF, 36'd0); do_adv(4'hF, 36'd0); do_adv(4'hF, 36'd0);

        // R3: back-to-back full writes fill the array
        cur_req = "R3";
        for (int a = 0; a < DEPTH; a++) do_wr(a, 4'h0, pat(a, 1));
        // R9: idle then back-to-back reads (R2)
        cur_req = "R9"; do_off(); do_off();
        cur_req = "R2";
        for (int a = DEPTH - 1; a >= 0; a--) do_rd(a);

        // R4 and R6: every lane mask, write then read the same word next edge
        for (int m = 0; m < 16; m++) begin
            cur_req = "R6";
            do_wr(m, 4'(m), pat(m, 40 + m));
            do_rd(m);
            cur_req = "R4";
            do_rd((m + 3) % DEPTH);
            do_rd(m);
        end

        // R1: every select pattern on a load
        cur_req = "R1";
        for (int s = 0; s < 8; s++) begin
            step(1'b0, 3'(s), 1'b1, 1'b0, AW'(s), 4'hF, 36'd0);
            do_off();
        end

        // R7: bursts in both orders from every start offset
        cur_req = "R7";
        for (int ilv = 0; ilv < 2; ilv++) begin
            do_off();
            burst_ilv = 1'(ilv);
            for (int st = 0; st < 4; st++) begin
                do_wr(4 + st, 4'h0, pat(st, 90 + ilv));
                for (int k = 1; k < 4; k++) do_adv(4'(k), pat(k, 70 + st));
                do_rd(4 + st);
                for (int k = 1; k < 4; k++) do_adv(4'hF, 36'd0);
            end
        end
        do_off();

        // R5: stalls inside a write's data phase and under a read result
        cur_req = "R5";
        do_wr(9, 4'h0, pat(9, 300));
        do_hold(); do_rd(9); do_hold(); do_hold(); do_rd(9); do_hold(); do_off();

        // mixed stream: alternation, deselects, bursts and stalls
        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 10;
            if (i % 500 == 0) burst_ilv = 1'($urandom);
            case (r)
                0, 1, 2: do_rd($urandom % DEPTH);
                3, 4, 5: do_wr($urandom % DEPTH, 4'($urandom), pat(i, 7));
                6:       do_off();
                7:       do_adv(4'($urandom), pat(i, 11));
                default: do_hold();
            endcase
        end
        cur_req = "R9"; do_off(); do_off();
        // final sweep reads the whole array back
        cur_req = "R4";
        for (int a = 0; a < DEPTH; a++) do_rd(a);
        do_off(); do_off();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule